// File: doc/BRIEF.md
# Hashed Page Table Group Search Engine

This block turns a segment-relative effective page into a walk over a hashed page table held in memory. It takes a segment descriptor (virtual segment ID, a segment-size bit picking 256 MB or 1 TB segments, and the segment's base page shift) together with an effective address. From these it forms a primary hash and a compare tag. It then reads the eight entries of the primary group one at a time through a synchronous read port. If no entry in the primary group qualifies, it searches the eight entries of the secondary group, whose group number is the complement of the primary hash.

An entry qualifies when its first word matches the compare tag under a fixed field mask, and when its page-size encoding decodes to a legal actual page size for the segment's base size. An entry whose tag matches but whose size encoding is illegal is passed over, and the search goes on. A single control input forces the base page size to 4 KiB. The result is either a hit carrying the entry address, both entry words and the actual page shift, or a miss.

Top module: `hpt_group_search`

## Requirements
- R1: After reset, `busy`, `done`, `hit` and `mem_rd_en` are low and `pte_shift` is 0.
- R2: The base page shift used for hashing, tagging and size decode is 12 when `force_4k` is high, and `seg_shift` (12, 16 or 24) otherwise.
- R3: For a 256 MB segment (`seg_1t`=0), the page index is `ea[27:0]` shifted right by the base shift, the hash is `vsid ^ index`, and the primary group is `hash & tbl_mask`.
- R4: For a 1 TB segment (`seg_1t`=1), the page index is `ea[39:0]` shifted right by the base shift, and the hash is `vsid ^ (vsid << 25) ^ index`.
- R5: Entry slot s of group g is read at `tbl_base + g*128 + s*16`. `mem_rd_en` is high for one cycle per read, and the data arrives on the next cycle with word0 in `mem_rdata[63:0]` and word1 in `mem_rdata[127:64]`. Slots are read 0 to 7 in order, and the secondary group `(~hash) & tbl_mask` is read only after all eight primary slots.
- R6: Tag compare on word0: bit 0 (valid) must be 1; bit 1 must be 0 in the primary group and 1 in the secondary group; bits [11:7] must equal bits [27:23] of the page-aligned in-segment offset; bits [VSID_W+11:12] must equal the VSID; bit 62 must equal `seg_1t`. All other bits are ignored.
- R7: Size decode uses word0 bit 2 (large). With large clear, the shift is 12 for base 12 and there is no match for any other base. With large set, base 12 or 16 gives 16 when word1[15:12]=1, and base 24 gives 24 when word1[23:12]=0. A tag-equal entry with no legal size is skipped.
- R8: A search ends with a one-cycle `done` pulse. On a hit, `hit`=1 and `pte_addr`, `pte_w0`, `pte_w1` and `pte_shift` hold the first qualifying entry in read order. These outputs stay unchanged until the next `done`.
- R9: When none of the 16 entries qualifies, `done` pulses with `hit`=0 and with `pte_addr`, `pte_w0`, `pte_w1` and `pte_shift` all 0.
- R10: A hit on global entry n (primary slots 0-7, secondary slots 8-15) raises `done` 2n+2 cycles after the edge that samples `start`. A miss raises it after 32 cycles.
- R11: `start` has no effect while `busy` is high; the running search finishes with its own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search; inputs sampled on this edge |
| seg_vsid | input | VSID_W | Virtual segment ID |
| seg_1t | input | 1 | 1 = 1 TB segment, 0 = 256 MB segment |
| seg_shift | input | 6 | Segment base page shift (12, 16, 24) |
| force_4k | input | 1 | Force base page shift to 12 |
| ea | input | EA_W | Effective address |
| tbl_base | input | PA_W | Table base address |
| tbl_mask | input | HASH_W | Group number mask |
| mem_rd_en | output | 1 | Table read strobe |
| mem_addr | output | PA_W | Table read address |
| mem_rdata | input | 128 | Entry read data, one cycle after strobe |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Last search found an entry |
| pte_addr | output | PA_W | Address of the found entry |
| pte_w0 | output | 64 | Found entry word0 |
| pte_w1 | output | 64 | Found entry word1 |
| pte_shift | output | 6 | Actual page shift of the found entry |

## Verification
A corrupted hash or group register sends reads to the wrong group. The first result then comes back as a miss, or as a wrong `pte_addr`, after the full 32 cycles. A slot counter or secondary flag that is off shows up in the `done` latency, which the bench predicts to the cycle for every target slot. Decoy entries placed ahead of the target cover each field of the tag and each size rule, so a compare or decode fault makes the engine stop early with the wrong words. A duplicate placed after the target catches a fault in search order.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_CHECK} srch_state_e;

  localparam logic [63:0] W0_VALID = 64'h1;
  localparam logic [63:0] W0_SEC   = 64'h2;
  localparam logic [63:0] W0_AVPN  = 64'h0F80;
  localparam int          W0_SEGB  = 62;
  localparam int          LARGE_B  = 2;

  function automatic logic [5:0] base_shift(input logic [5:0] seg_sh, input logic f4k);
    return f4k ? 6'd12 : seg_sh;
  endfunction

  // in-segment offset of the effective address
  function automatic logic [63:0] seg_offset(input logic [63:0] ea, input logic s1t);
    return s1t ? (ea & ((64'h1 << 40) - 64'h1)) : (ea & ((64'h1 << 28) - 64'h1));
  endfunction

  function automatic logic [63:0] prim_hash(input logic [63:0] vsid, input logic s1t,
                                             input logic [63:0] ea, input logic [5:0] sh);
    logic [63:0] pidx;
    pidx = seg_offset(ea, s1t) >> sh;
    return s1t ? (vsid ^ (vsid << 25) ^ pidx) : (vsid ^ pidx);
  endfunction

  function automatic logic [63:0] make_tag(input logic [63:0] vsid, input logic s1t,
                                            input logic [63:0] ea, input logic [5:0] sh);
    logic [63:0] epn;
    epn = seg_offset(ea, s1t) & ~((64'h1 << sh) - 64'h1);
    return W0_VALID | ((epn >> 16) & W0_AVPN) | (vsid << 12) | ({63'd0, s1t} << W0_SEGB);
  endfunction

  // actual page shift, 0 when the encoding is not legal for the base size
  function automatic logic [5:0] size_decode(input logic [63:0] w0, input logic [63:0] w1,
                                              input logic [5:0] bsh);
    logic [5:0] r;
    r = 6'd0;
    if (!w0[LARGE_B]) begin
      if (bsh == 6'd12) r = 6'd12;
    end else begin
      case (bsh)
        6'd12, 6'd16: if (w1[15:12] == 4'h1) r = 6'd16;
        6'd24:        if (w1[23:12] == 12'h0) r = 6'd24;
        default:      r = 6'd0;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/hpt_hash_gen.sv
module hpt_hash_gen
  import hpt_pkg::*;
#(
  parameter int VSID_W = 24,
  parameter int EA_W   = 64,
  parameter int HASH_W = 11
) (
  input  logic [VSID_W-1:0] vsid,
  input  logic              seg_1t,
  input  logic [5:0]        seg_shift,
  input  logic              force_4k,
  input  logic [EA_W-1:0]   ea,
  output logic [HASH_W-1:0] hash,
  output logic [63:0]       tag,
  output logic [5:0]        bshift
);
  logic [63:0] vsid64, ea64, hash64;

  always_comb begin
    vsid64 = 64'(vsid);
    ea64   = 64'(ea);
    bshift = base_shift(seg_shift, force_4k);
    hash64 = prim_hash(vsid64, seg_1t, ea64, bshift);
    hash   = hash64[HASH_W-1:0];
    tag    = make_tag(vsid64, seg_1t, ea64, bshift);
  end
endmodule

// File: rtl/hpt_entry_match.sv
module hpt_entry_match
  import hpt_pkg::*;
#(
  parameter int VSID_W = 24
) (
  input  logic [63:0] w0,
  input  logic [63:0] w1,
  input  logic [63:0] tag,
  input  logic        secondary,
  input  logic [5:0]  bshift,
  output logic        tag_eq,
  output logic [5:0]  size_sh,
  output logic        match
);
  localparam logic [63:0] VSID_M   = ((64'h1 << VSID_W) - 64'h1) << 12;
  localparam logic [63:0] CMP_MASK = W0_VALID | W0_SEC | W0_AVPN | VSID_M | (64'h1 << W0_SEGB);

  logic [63:0] want;

  always_comb begin
    want    = tag | (secondary ? W0_SEC : 64'h0);
    tag_eq  = ((w0 & CMP_MASK) == want);
    size_sh = size_decode(w0, w1, bshift);
    match   = tag_eq && (size_sh != 6'd0);
  end
endmodule

// File: rtl/hpt_group_search.sv
module hpt_group_search
  import hpt_pkg::*;
#(
  parameter int VSID_W = 24,
  parameter int EA_W   = 64,
  parameter int HASH_W = 11,
  parameter int PA_W   = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VSID_W-1:0] seg_vsid,
  input  logic              seg_1t,
  input  logic [5:0]        seg_shift,
  input  logic              force_4k,
  input  logic [EA_W-1:0]   ea,
  input  logic [PA_W-1:0]   tbl_base,
  input  logic [HASH_W-1:0] tbl_mask,
  output logic              mem_rd_en,
  output logic [PA_W-1:0]   mem_addr,
  input  logic [127:0]      mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              hit,
  output logic [PA_W-1:0]   pte_addr,
  output logic [63:0]       pte_w0,
  output logic [63:0]       pte_w1,
  output logic [5:0]        pte_shift
);
  localparam int SLOTS    = 8;
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int GRP_SH   = 7;
  localparam int ENT_SH   = 4;

  srch_state_e       state_q;
  logic [SLOT_W-1:0] slot_q;
  logic              sec_q;
  logic [HASH_W-1:0] hash_q, mask_q;
  logic [63:0]       tag_q;
  logic [5:0]        bsh_q;
  logic [PA_W-1:0]   base_q;

  logic [HASH_W-1:0] hash_w;
  logic [63:0]       tag_w;
  logic [5:0]        bsh_w;

  hpt_hash_gen #(.VSID_W(VSID_W), .EA_W(EA_W), .HASH_W(HASH_W)) u_hash (
    .vsid(seg_vsid), .seg_1t(seg_1t), .seg_shift(seg_shift), .force_4k(force_4k),
    .ea(ea), .hash(hash_w), .tag(tag_w), .bshift(bsh_w)
  );

  // named internal events
  logic [HASH_W-1:0] cur_grp;
  logic [PA_W-1:0]   cur_addr;
  logic              tag_eq, ent_match, in_check, entry_hit, last_entry, search_miss, accept;
  logic [5:0]        size_sh;

  assign cur_grp  = (sec_q ? ~hash_q : hash_q) & mask_q;
  assign cur_addr = base_q + (PA_W'(cur_grp) << GRP_SH) + (PA_W'(slot_q) << ENT_SH);

  hpt_entry_match #(.VSID_W(VSID_W)) u_match (
    .w0(mem_rdata[63:0]), .w1(mem_rdata[127:64]), .tag(tag_q), .secondary(sec_q),
    .bshift(bsh_q), .tag_eq(tag_eq), .size_sh(size_sh), .match(ent_match)
  );

  assign in_check    = (state_q == S_CHECK);
  assign entry_hit   = in_check && ent_match;
  assign last_entry  = sec_q && (slot_q == SLOT_W'(SLOTS - 1));
  assign search_miss = in_check && !ent_match && last_entry;
  assign accept      = (state_q == S_IDLE) && start;

  assign busy      = (state_q != S_IDLE);
  assign mem_rd_en = (state_q == S_READ);
  assign mem_addr  = cur_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      slot_q  <= '0;
      sec_q   <= 1'b0;
      hash_q  <= '0;
      mask_q  <= '0;
      tag_q   <= '0;
      bsh_q   <= '0;
      base_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          hash_q  <= hash_w;
          tag_q   <= tag_w;
          bsh_q   <= bsh_w;
          mask_q  <= tbl_mask;
          base_q  <= tbl_base;
          slot_q  <= '0;
          sec_q   <= 1'b0;
          state_q <= S_READ;
        end
        S_READ: state_q <= S_CHECK;
        S_CHECK: begin
          if (ent_match || last_entry) begin
            state_q <= S_IDLE;
          end else begin
            state_q <= S_READ;
            if (slot_q == SLOT_W'(SLOTS - 1)) begin
              slot_q <= '0;
              sec_q  <= 1'b1;
            end else begin
              slot_q <= slot_q + 1'b1;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      hit       <= 1'b0;
      pte_addr  <= '0;
      pte_w0    <= '0;
      pte_w1    <= '0;
      pte_shift <= '0;
    end else begin
      done <= entry_hit || search_miss;
      if (entry_hit) begin
        hit       <= 1'b1;
        pte_addr  <= cur_addr;
        pte_w0    <= mem_rdata[63:0];
        pte_w1    <= mem_rdata[127:64];
        pte_shift <= size_sh;
      end else if (search_miss) begin
        hit       <= 1'b0;
        pte_addr  <= '0;
        pte_w0    <= '0;
        pte_w1    <= '0;
        pte_shift <= '0;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_HIT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit) |-> (pte_shift != 6'd0 && pte_w0[0])); // R7
  AST_MISS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hit) |-> (pte_shift == 6'd0 && pte_w0 == 64'd0 && pte_w1 == 64'd0)); // R9
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_addr[ENT_SH-1:0] == base_q[ENT_SH-1:0])); // R5
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(tag_q) && $stable(hash_q) && $stable(base_q))); // R11
endmodule

// File: tb/hpt_group_search_tb.sv
module hpt_group_search_tb;
  localparam int VW = 24;
  localparam int HW = 4;
  localparam int PW = 16;
  localparam logic [PW-1:0] TBASE = 16'h2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [VW-1:0] vsid = '0;
  logic s1t = 1'b0;
  logic [5:0] seg_sh = 6'd12;
  logic f4k = 1'b0;
  logic [63:0] ea = '0;
  logic mem_rd_en, busy, done, hit;
  logic [PW-1:0] mem_addr, pte_addr;
  logic [127:0] mem_rdata = '0;
  logic [63:0] pte_w0, pte_w1;
  logic [5:0] pte_shift;

  logic [63:0] mem_lo [0:127];
  logic [63:0] mem_hi [0:127];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hpt_group_search #(.VSID_W(VW), .EA_W(64), .HASH_W(HW), .PA_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .seg_vsid(vsid), .seg_1t(s1t),
    .seg_shift(seg_sh), .force_4k(f4k), .ea(ea), .tbl_base(TBASE), .tbl_mask(4'hF),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy),
    .done(done), .hit(hit), .pte_addr(pte_addr), .pte_w0(pte_w0), .pte_w1(pte_w1),
    .pte_shift(pte_shift)
  );

  always @(posedge clk) begin
    if (mem_rd_en) begin
      logic [PW-1:0] off;
      off = mem_addr - TBASE;
      mem_rdata <= {mem_hi[off[10:4]], mem_lo[off[10:4]]};
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] w0_of(input logic v, input logic sc, input logic lg,
                                         input logic [63:0] vs, input logic t1, input logic [63:0] av);
    return {63'd0, v} + {62'd0, sc, 1'b0} + (lg ? 64'd4 : 64'd0) + av * 128
           + vs * 4096 + (t1 ? (64'd1 << 62) : 64'd0);
  endfunction

  task automatic put(input int g, input int s, input logic [63:0] a, input logic [63:0] b);
    mem_lo[g*8+s] = a;
    mem_hi[g*8+s] = b;
  endtask

  // n: global target index 0..15, 16 = miss
  task automatic run_case(input logic t1, input logic [5:0] sh, input logic fk,
                          input logic [VW-1:0] vs, input logic [63:0] a, input int n,
                          input bit interfere);
    logic [63:0] segsz, off, pidx, hsh, epn, av, tw0, tw1, exp_addr, dw0, dw1;
    logic [5:0] bs, exp_sh;
    int g0, g1, tg, ts, k;
    logic lg;
    bs    = fk ? 6'd12 : sh;                           // R2
    segsz = t1 ? (64'd1 << 40) : (64'd1 << 28);
    off   = a % segsz;
    pidx  = off / (64'd1 << bs);
    hsh   = 64'(vs) ^ pidx ^ (t1 ? 64'(vs) * 64'd33554432 : 64'd0); // R3 R4
    g0    = int'(hsh % 16);
    g1    = 15 - g0;
    epn   = pidx * (64'd1 << bs);
    av    = (epn / (64'd1 << 23)) % 32;                // R6
    for (int i = 0; i < 128; i++) begin mem_lo[i] = 64'd0; mem_hi[i] = 64'd0; end
    // decoys ahead of the target (or everywhere on a miss)
    for (int j = 0; j < 16; j++) begin
      if (j < n) begin
        logic sc;
        sc = (j >= 8);
        case (j % 4)
          0: dw0 = w0_of(1'b0, sc, bs != 12 ? 1'b1 : 1'b0, 64'(vs), t1, av);
          1: dw0 = w0_of(1'b1, !sc, bs != 12 ? 1'b1 : 1'b0, 64'(vs), t1, av);
          2: dw0 = w0_of(1'b1, sc, bs == 12 ? 1'b1 : 1'b0, 64'(vs), t1, av);
          default: dw0 = w0_of(1'b1, sc, bs != 12 ? 1'b1 : 1'b0, 64'(vs ^ 24'h1), t1, av);
        endcase
        dw1 = (bs == 24) ? 64'h0 : ((j % 4 == 2) ? 64'h0 : 64'h1000);
        put(sc ? g1 : g0, j % 8, dw0, dw1);
      end
    end
    lg = (bs != 12) || (n % 2 == 1);
    exp_sh = (bs == 12) ? (lg ? 6'd16 : 6'd12) : bs;   // R7
    if (bs == 24)     tw1 = 64'h00AB_CD00_0000_0000 + (64'(n) << 24);
    else if (lg)      tw1 = 64'h0055_AA00_0000_1000 + (64'(n) << 16);
    else              tw1 = 64'h0033_CC00_0000_0000 + (64'(n) << 12);
    tw0 = w0_of(1'b1, n >= 8, lg, 64'(vs), t1, av) | 64'h78; // ignored bits set
    tg = (n >= 8) ? g1 : g0;
    ts = n % 8;
    exp_addr = 64'd0;
    if (n < 16) begin
      put(tg, ts, tw0, tw1);
      if (ts < 7) put(tg, ts + 1, tw0, tw1 ^ 64'hFFFF_0000_0000_0000); // later duplicate
      exp_addr = 64'(TBASE) + 64'(tg) * 128 + 64'(ts) * 16;          // R5
    end
    @(negedge clk);
    vsid = vs; s1t = t1; seg_sh = sh; f4k = fk; ea = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k < 100) begin
      @(negedge clk);
      k++;
      if (interfere && k == 4) begin
        vsid = vs ^ 24'h5A5A5; ea = ~a; start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    chk(interfere ? "R11 done" : "R8 done", 64'(done), 64'd1);
    if (n < 16) begin
      chk(interfere ? "R11 hit" : "R8 hit", 64'(hit), 64'd1);
      chk("R5 pte_addr", 64'(pte_addr), exp_addr);
      chk("R6 pte_w0", pte_w0, tw0);
      chk("R8 pte_w1", pte_w1, tw1);
      chk("R7 pte_shift", 64'(pte_shift), 64'(exp_sh));
      chk("R10 hit latency", 64'(k), 64'(2 * n + 2));
    end else begin
      chk("R9 miss hit", 64'(hit), 64'd0);
      chk("R9 miss addr", 64'(pte_addr), 64'd0);
      chk("R9 miss words", pte_w0 | pte_w1, 64'd0);
      chk("R9 miss shift", 64'(pte_shift), 64'd0);
      chk("R10 miss latency", 64'(k), 64'd32);
    end
    @(negedge clk);
    chk("R8 done pulse", 64'(done), 64'd0);
    if (n < 16) chk("R8 hold", pte_w1, tw1);
  endtask

  initial begin
    int slots [7] = '{0, 3, 7, 8, 12, 15, 16};
    repeat (3) @(negedge clk);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 hit", 64'(hit), 64'd0);
    chk("R1 rd_en", 64'(mem_rd_en), 64'd0);
    chk("R1 shift", 64'(pte_shift), 64'd0);
    rst_n = 1'b1;
    for (int c = 0; c < 12; c++) begin
      logic [5:0] sh;
      sh = ((c / 2) % 3 == 0) ? 6'd12 : (((c / 2) % 3 == 1) ? 6'd16 : 6'd24);
      for (int s = 0; s < 7; s++)
        run_case(c[0], sh, c >= 6, 24'h3A5C1 + 24'(c) * 24'h1111,
                 64'h0000_00F3_9ABC_DE00 + 64'(c) * 64'h0123_4567 + 64'(s) * 64'h0080_0000,
                 slots[s], 1'b0);
    end
    run_case(1'b0, 6'd16, 1'b0, 24'h00BEE, 64'h0000_0000_0ACE_1000, 15, 1'b1);
    run_case(1'b1, 6'd24, 1'b0, 24'h7C0DE, 64'h0000_0012_3456_7000, 16, 1'b1);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule